// File: doc/BRIEF.md
# Serial CRC-15 Frame Check for Classic CAN

This block checks the 15-bit frame check sequence of a classic CAN frame while the frame is still arriving, one bit at a time. An upstream receiver samples the line once per bit time and presents each sample with a valid strobe. It clears the valid strobe for stuff bits, so the checker never sees them as data. The receiver also issues a start-of-frame clear and raises a flag while the CRC field is on the line.

From zero, the checker builds a remainder over every accepted bit, beginning with the start-of-frame bit. Once the CRC field begins, the remainder stops changing. The checker then compares the received CRC bits against it, most significant bit first. The first valid bit after the fifteenth CRC bit is taken as the CRC delimiter.

One cycle after the delimiter, a single-cycle done pulse reports the verdict on crc_ok. Because the receiver marks where the CRC field starts, the checker works for any data length. The register width, generator polynomial, initial value and the structure of the XOR network are all parameters.

Top module: `can_crc15_chk`

## Requirements
- R1: While rst_n is low at a clock edge, the edge clears remainder to zero and clears done and crc_ok to 0.
- R2: A cycle with sof_clr high loads the initial value (zero) into the register. If bit_vld is also high in that cycle, the bit is processed as the first bit of the new frame, starting from zero.
- R3: Outside the CRC field, each valid bit updates the register. The feedback is bit_in XOR register bit 14. The register shifts left by one place and a 0 enters bit 0. When the feedback is 1, the shifted value is XORed with 15'h4599.
- R4: A cycle with bit_vld low (such as a stuff bit) changes neither remainder, nor done, nor crc_ok, whatever the value on bit_in.
- R5: The first valid bit with crc_field high starts the compare phase. From then on, remainder holds its value until the next sof_clr.
- R6: The k-th valid bit of the CRC field (k = 0..14) is compared with remainder bit 14-k. Any mismatch makes that frame's crc_ok 0.
- R7: The first valid bit after the fifteenth CRC bit is the delimiter. done is high for exactly the one cycle after the delimiter is accepted. In that same cycle crc_ok becomes 1 only if all 15 CRC bits matched and the delimiter was 1, and crc_ok then holds until the next sof_clr or reset.
- R8: Valid bits that arrive after the delimiter and before the next sof_clr are ignored: remainder and crc_ok stay unchanged and done stays 0.
- R9: A sof_clr in mid-frame discards the partial frame, resets the compare state and clears crc_ok. The following frame is then checked on its own.
- R10: The checker works for any number of bits before the CRC field, including a frame with no data bytes and a length that is not a whole number of bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sof_clr | input | 1 | Start-of-frame clear, one cycle |
| bit_vld | input | 1 | Sample strobe; low for stuff bits and idle cycles |
| bit_in | input | 1 | Sampled, destuffed line bit |
| crc_field | input | 1 | High while the bit belongs to the CRC field |
| remainder | output | 15 | Running CRC register |
| done | output | 1 | One-cycle pulse after the delimiter |
| crc_ok | output | 1 | Frame CRC and delimiter verdict |

## Verification
The assertions assume a few things about the receiver. It raises sof_clr before the start-of-frame bit, or in the same cycle as it. It keeps bit_vld low for every stuff bit. It holds crc_field high for the fifteen CRC bits that follow the last data bit. The bench builds every frame to respect these rules. It inserts stuff bits with the strobe low after five equal line bits, and it spreads random idle cycles between bits with random line values. It sets the CRC flag only at the real field boundary. The one deliberate break is a sof_clr in mid-frame, which the block must treat as a restart.

// File: rtl/can_crc15_pkg.sv
package can_crc15_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_GEN   = 2'd1,
      PH_CMP   = 2'd2,
      PH_DELIM = 2'd3
   } crc_phase_e;

   localparam int STEP_PER_BIT = 0;
   localparam int STEP_VECTOR  = 1;

endpackage

// File: rtl/crc_serial_step.sv
module crc_serial_step #(
   parameter int             W    = 15,
   parameter logic [W-1:0]   POLY = 15'h4599,
   parameter int             IMPL = 0
) (
   input  logic [W-1:0] cur,
   input  logic         din,
   output logic [W-1:0] nxt
);
   import can_crc15_pkg::*;

   if (W < 2) begin : g_bad_width
      $error("crc_serial_step: W must be at least 2");
   end
   if (POLY[0] != 1'b1) begin : g_bad_poly
      $error("crc_serial_step: generator must have its constant term set");
   end
   if (IMPL != STEP_PER_BIT && IMPL != STEP_VECTOR) begin : g_bad_impl
      $error("crc_serial_step: unknown IMPL");
   end

   logic fb;
   assign fb = din ^ cur[W-1];

   if (IMPL == STEP_PER_BIT) begin : g_per_bit
      assign nxt[0] = fb & POLY[0];
      for (genvar i = 1; i < W; i++) begin : g_tap
         if (POLY[i]) begin : g_xor
            assign nxt[i] = cur[i-1] ^ fb;
         end else begin : g_pass
            assign nxt[i] = cur[i-1];
         end
      end
   end else begin : g_vector
      assign nxt = {cur[W-2:0], 1'b0} ^ ({W{fb}} & POLY);
   end

endmodule

// File: rtl/crc_frame_ctrl.sv
module crc_frame_ctrl (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sof_clr,
   input  logic                       bit_vld,
   input  logic                       crc_field,
   input  logic                       cmp_last,
   output logic                       gen_en,
   output logic                       cmp_en,
   output logic                       delim_en,
   output can_crc15_pkg::crc_phase_e  phase_o
);
   import can_crc15_pkg::*;

   crc_phase_e phase_q, phase_eff, phase_d;

   always_comb begin
      phase_eff = sof_clr ? PH_GEN : phase_q;
      gen_en    = bit_vld && !crc_field && (phase_eff == PH_GEN);
      cmp_en    = bit_vld && (((phase_eff == PH_GEN) && crc_field) ||
                              (phase_eff == PH_CMP));
      delim_en  = bit_vld && (phase_eff == PH_DELIM);
      phase_d   = phase_eff;
      if (cmp_en) begin
         phase_d = cmp_last ? PH_DELIM : PH_CMP;
      end else if (delim_en) begin
         phase_d = PH_IDLE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) phase_q <= PH_IDLE;
      else        phase_q <= phase_d;
   end

   assign phase_o = phase_q;

   AST_DELIM_AFTER_CMP: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_DELIM) |-> ($past(phase_q) == PH_CMP) || ($past(phase_q) == PH_GEN) ||
                                 ($past(phase_q) == PH_DELIM)); // R7

endmodule

// File: rtl/crc_field_cmp.sv
module crc_field_cmp #(
   parameter int W = 15
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sof_clr,
   input  logic         cmp_en,
   input  logic         bit_in,
   input  logic [W-1:0] rem_eff,
   output logic         cmp_last,
   output logic         match
);
   localparam int CW = $clog2(W + 1);
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   logic [CW-1:0] cnt_q, cnt_eff, idx;
   logic          match_q, match_eff, bit_hit;

   always_comb begin
      cnt_eff   = sof_clr ? '0 : cnt_q;
      match_eff = sof_clr ? 1'b1 : match_q;
      idx       = LAST - cnt_eff;
      bit_hit   = (bit_in == rem_eff[idx]);
      cmp_last  = (cnt_eff == LAST);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         match_q <= 1'b1;
      end else if (cmp_en) begin
         cnt_q   <= cmp_last ? '0 : cnt_eff + 1'b1;
         match_q <= match_eff & bit_hit;
      end else if (sof_clr) begin
         cnt_q   <= '0;
         match_q <= 1'b1;
      end
   end

   assign match = match_q;

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CW'(W)); // R6
   AST_MISS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (!match_q && !sof_clr) |=> !match_q); // R6

endmodule

// File: rtl/can_crc15_chk.sv
module can_crc15_chk #(
   parameter int                CRC_W     = 15,
   parameter logic [CRC_W-1:0]  GEN_POLY  = 15'h4599,
   parameter logic [CRC_W-1:0]  CRC_INIT  = '0,
   parameter int                STEP_IMPL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sof_clr,
   input  logic             bit_vld,
   input  logic             bit_in,
   input  logic             crc_field,
   output logic [CRC_W-1:0] remainder,
   output logic             done,
   output logic             crc_ok
);
   import can_crc15_pkg::*;

   logic [CRC_W-1:0] crc_q, rem_eff, crc_nxt;
   logic             gen_en, cmp_en, delim_en, cmp_last, match;
   logic             done_q, ok_q;
   crc_phase_e       phase;

   assign rem_eff = sof_clr ? CRC_INIT : crc_q;

   crc_serial_step #(.W(CRC_W), .POLY(GEN_POLY), .IMPL(STEP_IMPL)) u_step (
      .cur (rem_eff),
      .din (bit_in),
      .nxt (crc_nxt)
   );

   crc_frame_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .sof_clr   (sof_clr),
      .bit_vld   (bit_vld),
      .crc_field (crc_field),
      .cmp_last  (cmp_last),
      .gen_en    (gen_en),
      .cmp_en    (cmp_en),
      .delim_en  (delim_en),
      .phase_o   (phase)
   );

   crc_field_cmp #(.W(CRC_W)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .sof_clr  (sof_clr),
      .cmp_en   (cmp_en),
      .bit_in   (bit_in),
      .rem_eff  (rem_eff),
      .cmp_last (cmp_last),
      .match    (match)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       crc_q <= '0;
      else if (gen_en)  crc_q <= crc_nxt;
      else if (sof_clr) crc_q <= CRC_INIT;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         ok_q   <= 1'b0;
      end else begin
         done_q <= delim_en;
         if (sof_clr)       ok_q <= 1'b0;
         else if (delim_en) ok_q <= match & bit_in;
      end
   end

   assign remainder = crc_q;
   assign done      = done_q;
   assign crc_ok    = ok_q;

   AST_CLR_LOADS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      (sof_clr && !bit_vld) |=> (crc_q == CRC_INIT)); // R2
   AST_STROBE_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_vld && !sof_clr) |=> ($stable(crc_q) && !done_q)); // R4
   AST_FROZEN_AFTER_GEN: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase != PH_GEN) && !sof_clr) |=> $stable(crc_q)); // R5
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R7
   AST_OK_RISES_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ok_q) |-> done_q); // R7
   AST_IDLE_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase == PH_IDLE) && !sof_clr) |=> ($stable(ok_q) && !done_q)); // R8

endmodule

// File: tb/tb_can_crc15_chk.sv
module tb_can_crc15_chk;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sof_clr = 1'b0, bit_vld = 1'b0, bit_in = 1'b0, crc_field = 1'b0;
   logic [14:0] remainder;
   logic        done, crc_ok;
   int          total = 0, bad = 0;
   bit          finished = 0;

   always #2 clk = ~clk;

   can_crc15_chk dut (
      .clk(clk), .rst_n(rst_n), .sof_clr(sof_clr), .bit_vld(bit_vld),
      .bit_in(bit_in), .crc_field(crc_field),
      .remainder(remainder), .done(done), .crc_ok(crc_ok)
   );

   function automatic logic [14:0] ref_step(input logic [14:0] r, input logic b);
      logic fb;
      fb = b ^ r[14];
      r  = {r[13:0], 1'b0};
      if (fb) r = r ^ 15'h4599;
      return r;
   endfunction

   function automatic logic [14:0] ref_crc(input logic [0:127] p, input int n);
      logic [14:0] r = '0;
      for (int i = 0; i < n; i++) r = ref_step(r, p[i]);
      return r;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drv(input logic v, input logic vld, input logic fld, input logic clr);
      @(negedge clk);
      bit_in = v; bit_vld = vld; crc_field = fld; sof_clr = clr;
   endtask

   task automatic settle();
      @(posedge clk); #1;
   endtask

   function automatic logic [0:127] make_frame(input int dlc, output int n);
      logic [0:127] p = '0;
      int k = 0;
      p[k++] = 1'b0;
      for (int i = 0; i < 11; i++) p[k++] = 1'($urandom);
      p[k++] = 1'b0; p[k++] = 1'b0; p[k++] = 1'b0;
      for (int i = 3; i >= 0; i--) p[k++] = 1'(dlc >> i);
      for (int i = 0; i < 8 * dlc; i++) p[k++] = 1'($urandom);
      n = k;
      return p;
   endfunction

   task automatic run_frame(input logic [0:127] pay, input int npay, input int flip_pay,
                            input int flip_crc, input logic delim, input bit bad_stuff,
                            input string tag);
      logic [14:0] crcv, rem_exp;
      logic [0:127] sent;
      logic last_line, v, exp_ok;
      int run;
      crcv = ref_crc(pay, npay);
      sent = pay;
      if (flip_pay >= 0) sent[flip_pay] = ~sent[flip_pay];
      rem_exp = ref_crc(sent, npay);
      if (flip_crc >= 0) crcv[14 - flip_crc] = ~crcv[14 - flip_crc];
      exp_ok = (flip_pay < 0) && (flip_crc < 0) && delim;
      drv(1'b1, 1'b0, 1'b0, 1'b1);
      run = 0; last_line = 1'b1;
      for (int i = 0; i < npay + 15; i++) begin
         v = (i < npay) ? sent[i] : crcv[14 - (i - npay)];
         if (($urandom % 4) == 0) drv(1'($urandom), 1'b0, i >= npay, 1'b0);
         drv(v, 1'b1, i >= npay, 1'b0);
         if (v == last_line) run++; else run = 1;
         last_line = v;
         if (run == 5) begin
            // stuff bit, strobe low (R4); a wrong stuff value must not matter
            drv(bad_stuff ? v : ~v, 1'b0, i >= npay, 1'b0);
            last_line = ~v; run = 1;
         end
      end
      drv(delim, 1'b1, 1'b0, 1'b0);
      settle();
      chk({"R7 done after delimiter ", tag}, done, 1);
      chk({"R6 R7 crc_ok ", tag}, crc_ok, exp_ok);
      chk({"R5 frozen remainder ", tag}, remainder, rem_exp);
      drv(1'b0, 1'b0, 1'b0, 1'b0);
      settle();
      chk({"R7 done one cycle ", tag}, done, 0);
      chk({"R7 crc_ok held ", tag}, crc_ok, exp_ok);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [0:127] p;
      logic [14:0] r, hold;
      logic okh;
      int n;
      void'($urandom(32'd1234));

      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset remainder", remainder, 0);
      chk("R1 reset done", done, 0);
      chk("R1 reset crc_ok", crc_ok, 0);
      @(negedge clk); rst_n = 1'b1;

      // R3: per-bit update, with strobe-low cycles between (R4)
      drv(1'b0, 1'b0, 1'b0, 1'b1);
      r = '0;
      for (int i = 0; i < 40; i++) begin
         logic b;
         b = 1'($urandom);
         drv(b, 1'b1, 1'b0, 1'b0);
         r = ref_step(r, b);
         settle();
         chk("R3 per-bit remainder", remainder, r);
         drv(1'($urandom), 1'b0, 1'b0, 1'b0);
         settle();
         chk("R4 strobe low holds", remainder, r);
      end

      // R2: clear together with first bit
      drv(1'b1, 1'b1, 1'b0, 1'b1);
      settle();
      chk("R2 clear with first bit", remainder, 15'h4599);
      drv(1'b0, 1'b0, 1'b0, 1'b1);
      settle();
      chk("R2 clear to zero", remainder, 0);

      // R10 directed lengths
      p = make_frame(0, n);
      run_frame(p, n, -1, -1, 1'b1, 0, "R10 dlc0");
      p = make_frame(8, n);
      run_frame(p, n, -1, -1, 1'b1, 0, "R10 dlc8");
      p = '0;
      for (int i = 1; i < 23; i++) p[i] = 1'($urandom);
      run_frame(p, 23, -1, -1, 1'b1, 0, "R10 odd length");
      p = '0;
      run_frame(p, 30, -1, -1, 1'b1, 1, "R4 wrong stuff values");

      // R8: bits after the delimiter ignored
      hold = remainder; okh = crc_ok;
      for (int i = 0; i < 6; i++) begin
         drv(1'($urandom), 1'b1, 1'($urandom), 1'b0);
         settle();
         chk("R8 remainder after delimiter", remainder, hold);
         chk("R8 no done", done, 0);
         chk("R8 crc_ok held", crc_ok, okh);
      end

      // R9: restart in mid-frame
      p = make_frame(4, n);
      drv(1'b0, 1'b0, 1'b0, 1'b1);
      for (int i = 0; i < 30; i++) drv(p[i], 1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 5; i++) drv(1'($urandom), 1'b1, 1'b1, 1'b0);
      drv(1'b0, 1'b0, 1'b0, 1'b1);
      settle();
      chk("R9 restart clears remainder", remainder, 0);
      chk("R9 restart clears crc_ok", crc_ok, 0);
      p = make_frame(3, n);
      run_frame(p, n, -1, -1, 1'b1, 0, "R9 after restart");

      // corruptions
      p = make_frame(2, n);
      run_frame(p, n, n - 1, -1, 1'b1, 0, "R6 last data bit flipped");
      p = make_frame(5, n);
      run_frame(p, n, -1, 0, 1'b1, 0, "R6 crc msb flipped");
      p = make_frame(5, n);
      run_frame(p, n, -1, 14, 1'b1, 0, "R6 crc lsb flipped");
      p = make_frame(1, n);
      run_frame(p, n, -1, -1, 1'b0, 0, "R7 delimiter dominant");

      // random mix
      for (int f = 0; f < 30; f++) begin
         int dlc, sel, fp, fc;
         dlc = int'($urandom % 9);
         p = make_frame(dlc, n);
         sel = int'($urandom % 4);
         fp = (sel == 1) ? int'($urandom % n) : -1;
         fc = (sel == 2) ? int'($urandom % 15) : -1;
         run_frame(p, n, fp, fc, sel != 3, f % 2 == 1, "R6 random frame");
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule